// File: doc/BRIEF.md
# Long Fixed-Latency Data Delay Line

This block holds every input word for a fixed number of clock cycles (512 by default) and then presents it at the output. It suits paths that must stay in step with a long pipeline elsewhere on the chip, such as matching the latency of a lookup engine or of a slow arithmetic unit. The delay is kept in an addressed storage array used as a circular buffer. A write pointer and a read pointer both step once per clock and wrap at the end of the array, so no long chain of registers shifts each cycle.

The input and output widths are parameters. With equal widths the block is a plain delay. When the output is twice the input width, each pair of valid input words leaves as one wide word. When the input is twice the output width, each wide input leaves as two narrow words on consecutive cycles. The storage always holds narrow lanes, so every mode uses the same array of `DELAY` entries. Cycles with the input valid low still advance the pointers, so gaps in the input stream reach the output unchanged.

Top module: `dly_line`

## Requirements
- R1: With `IN_W == OUT_W`, a word with `in_valid` high in cycle c appears on `out_data` with `out_valid` high in cycle c+DELAY.
- R2: Outside the cycles named in R1, R6 and R8, `out_valid` is low: a cycle with `in_valid` low leaves a cycle with `out_valid` low, DELAY cycles later.
- R3: For the first DELAY cycles after synchronous reset is released (cycles 0 to DELAY-1), `out_valid` stays low, whatever the storage held.
- R4: A reset in the middle of a stream drops every word in flight: `out_valid` is low while `rst` is high and for DELAY cycles after its release.
- R5: With `OUT_W == 2*IN_W`, two valid input words form one output word: the earlier one in bits [IN_W-1:0] and the later one in bits [2*IN_W-1:IN_W].
- R6: In packing mode the output word is valid for exactly one cycle, DELAY cycles after the cycle of the later input word of its pair.
- R7: In packing mode the pairs are counted over valid words only, starting from the first valid word after reset. Idle cycles between the two halves of a pair do not break the pair.
- R8: With `IN_W == 2*OUT_W`, a wide word valid in cycle c gives its bits [OUT_W-1:0] in cycle c+DELAY and its bits [2*OUT_W-1:OUT_W] in cycle c+DELAY+1, both with `out_valid` high.
- R9: In splitting mode the block assumes wide inputs arrive no more often than every second cycle. At that full rate the output is valid on every cycle with no gap.
- R10: Both pointers wrap from DELAY-1 to 0, and the read pointer is always one slot ahead of the write pointer. Latency and data stay correct over runs of several times DELAY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The word on `in_data` is to be delayed |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | The word on `out_data` is a delayed input |
| out_data | output | OUT_W | Delayed (and possibly packed or split) word |

## Verification
Every result is due a fixed number of cycles after the input that causes it: DELAY cycles for a plain word, DELAY after the second half of a pair for a packed word, and DELAY and DELAY+1 for the two halves of a split word. The bench stores each expected output in a per-cycle table at exactly that future cycle index when it drives the input. In each cycle it samples all outputs one nanosecond after the clock edge and compares them with that cycle's entry. An entry that holds no word means the output must be invalid. The first DELAY cycles after each reset are checked this way for silence.

// File: rtl/dly_line_pkg.sv
package dly_line_pkg;

  typedef enum logic [1:0] {
    WM_SAME  = 2'd0,
    WM_PACK  = 2'd1,
    WM_SPLIT = 2'd2
  } wmode_e;

  // Width-change mode chosen from the port widths.
  function automatic wmode_e f_mode(input int in_w, input int out_w);
    if (out_w == 2 * in_w) return WM_PACK;
    if (in_w == 2 * out_w) return WM_SPLIT;
    return WM_SAME;
  endfunction

  // Width of one storage lane: the narrower port.
  function automatic int f_lane(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int f_ptr_w(input int depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction

  // Next slot of a ring of `depth` entries.
  function automatic int f_next_slot(input int slot, input int depth);
    return (slot >= depth - 1) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/dly_ring.sv
module dly_ring
  import dly_line_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_v,
  input  logic [W-1:0]                 wr_d,
  output logic                         rd_v,
  output logic [W-1:0]                 rd_d,
  output logic [f_ptr_w(DEPTH)-1:0]    wr_ptr_o,
  output logic [f_ptr_w(DEPTH)-1:0]    rd_ptr_o,
  output logic                         primed_o
);
  localparam int PW = f_ptr_w(DEPTH);
  localparam int SW = W + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [SW-1:0] mem [DEPTH];
  logic [SW-1:0] rd_q;
  logic [PW-1:0] wr_ptr, rd_ptr, fill;
  logic          primed;

  // Read the slot the next cycle will overwrite; write the current one.
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= {wr_v, wr_d};
    rd_q        <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= PW'(f_next_slot(0, DEPTH));
      fill   <= '0;
      primed <= 1'b0;
    end else begin
      wr_ptr <= PW'(f_next_slot(int'(wr_ptr), DEPTH));
      rd_ptr <= PW'(f_next_slot(int'(rd_ptr), DEPTH));
      if (fill != LAST) fill <= fill + 1'b1;
      primed <= (fill == LAST);
    end
  end

  assign rd_v     = rd_q[SW-1] & primed;
  assign rd_d     = rd_q[W-1:0];
  assign wr_ptr_o = wr_ptr;
  assign rd_ptr_o = rd_ptr;
  assign primed_o = primed;
endmodule

// File: rtl/dly_split.sv
module dly_split #(
  parameter int NW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [2*NW-1:0] in_d,
  output logic            out_v,
  output logic [NW-1:0]   out_d
);
  logic          pend;
  logic [NW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= in_v;
  end

  always_ff @(posedge clk) begin
    if (in_v) hi_q <= in_d[2*NW-1:NW];
  end

  // Low half goes straight in, high half one cycle later.
  assign out_v = in_v | pend;
  assign out_d = in_v ? in_d[NW-1:0] : hi_q;
endmodule

// File: rtl/dly_pack.sv
module dly_pack #(
  parameter int NW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [NW-1:0]   in_d,
  output logic            out_v,
  output logic [2*NW-1:0] out_d
);
  logic          ph;
  logic [NW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)       ph <= 1'b0;
    else if (in_v) ph <= ~ph;
  end

  always_ff @(posedge clk) begin
    if (in_v && !ph) lo_q <= in_d;
  end

  // Second word of a pair completes the wide word in the same cycle.
  assign out_v = in_v & ph;
  assign out_d = {in_d, lo_q};
endmodule

// File: rtl/dly_line.sv
module dly_line
  import dly_line_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 32,
  parameter int DELAY = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam wmode_e MODE   = f_mode(IN_W, OUT_W);
  localparam int     LANE_W = f_lane(IN_W, OUT_W);
  localparam int     PTR_W  = f_ptr_w(DELAY);

  // Internal events, named for the checker.
  logic              ev_ring_wr_v;
  logic [LANE_W-1:0] ev_ring_wr_d;
  logic              ev_ring_out_v;
  logic [LANE_W-1:0] ring_out_d;
  logic [PTR_W-1:0]  ev_wr_ptr, ev_rd_ptr;
  logic              ev_primed;

  generate
    if (MODE == WM_SPLIT) begin : g_in_split
      dly_split #(.NW(LANE_W)) u_split (
        .clk(clk), .rst(rst), .in_v(in_valid), .in_d(in_data),
        .out_v(ev_ring_wr_v), .out_d(ev_ring_wr_d)
      );
    end else begin : g_in_direct
      assign ev_ring_wr_v = in_valid;
      assign ev_ring_wr_d = in_data[LANE_W-1:0];
    end
  endgenerate

  dly_ring #(.W(LANE_W), .DEPTH(DELAY)) u_ring (
    .clk(clk), .rst(rst),
    .wr_v(ev_ring_wr_v), .wr_d(ev_ring_wr_d),
    .rd_v(ev_ring_out_v), .rd_d(ring_out_d),
    .wr_ptr_o(ev_wr_ptr), .rd_ptr_o(ev_rd_ptr), .primed_o(ev_primed)
  );

  generate
    if (MODE == WM_PACK) begin : g_out_pack
      dly_pack #(.NW(LANE_W)) u_pack (
        .clk(clk), .rst(rst), .in_v(ev_ring_out_v), .in_d(ring_out_d),
        .out_v(out_valid), .out_d(out_data)
      );
    end else begin : g_out_direct
      assign out_valid = ev_ring_out_v;
      assign out_data  = ring_out_d;
    end
  endgenerate
endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk
  import dly_line_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 32,
  parameter int DELAY = 512
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic                      ring_wr_v,
  input logic                      ring_out_v,
  input logic [f_ptr_w(DELAY)-1:0] wr_ptr,
  input logic [f_ptr_w(DELAY)-1:0] rd_ptr,
  input logic                      primed
);
  localparam wmode_e MODE = f_mode(IN_W, OUT_W);
  localparam int PW = f_ptr_w(DELAY);
  localparam int AW = PW + 1;
  localparam logic [AW-1:0] FULL = AW'(DELAY);

  logic [AW-1:0] age;
  logic [PW-1:0] wr_ptr_d;
  logic          in_valid_d;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != FULL) age <= age + 1'b1;
    wr_ptr_d   <= wr_ptr;
    in_valid_d <= in_valid;
  end

  // R3
  early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (age < FULL) |-> (!out_valid && !ring_out_v));

  // R3
  primed_age_chk: assert property (@(posedge clk) disable iff (rst)
    primed == (age == FULL));

  // R10
  ptr_lead_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ptr == PW'(f_next_slot(int'(wr_ptr), DELAY)));

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (age != '0) |-> (wr_ptr == PW'(f_next_slot(int'(wr_ptr_d), DELAY))));

  // R2
  no_phantom_write_chk: assert property (@(posedge clk) disable iff (rst)
    ((age != '0) && !in_valid && !in_valid_d) |-> !ring_wr_v);

  generate
    if (MODE == WM_PACK) begin : g_pack
      // R6
      pack_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
      // R5
      pack_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ring_out_v);
    end
    if (MODE == WM_SPLIT) begin : g_split
      // R9
      split_rate_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);
      // R8
      split_hi_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ring_wr_v);
    end
  endgenerate
endmodule

bind dly_line dly_line_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .ring_wr_v(ev_ring_wr_v), .ring_out_v(ev_ring_out_v),
  .wr_ptr(ev_wr_ptr), .rd_ptr(ev_rd_ptr), .primed(ev_primed)
);

// File: tb/dly_line_bench.sv
module dly_line_bench;
  localparam int DLY  = 512;
  localparam int NCYC = 4096;
  localparam int NSEG = 8;
  // Stimulus table: {cycles, valid mask indexed by cycle % 4}.
  localparam logic [15:0] SEG [NSEG] = '{
    {12'd700, 4'b1111}, {12'd300, 4'b0101}, {12'd200, 4'b0000},
    {12'd400, 4'b1011}, {12'd150, 4'b1000}, {12'd600, 4'b1111},
    {12'd250, 4'b0110}, {12'd600, 4'b0000}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz
  logic rst = 1'b1;

  logic        b_iv = 0, p_iv = 0, s_iv = 0;
  logic [31:0] b_id = 0, p_id = 0;
  logic [63:0] s_id = 0;
  logic        b_ov, p_ov, s_ov;
  logic [31:0] b_od, s_od;
  logic [63:0] p_od;

  dly_line #(.IN_W(32), .OUT_W(32), .DELAY(DLY)) u_dly_line (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_data(b_id),
    .out_valid(b_ov), .out_data(b_od));
  dly_line #(.IN_W(32), .OUT_W(64), .DELAY(DLY)) u_dly_line_pk (
    .clk(clk), .rst(rst), .in_valid(p_iv), .in_data(p_id),
    .out_valid(p_ov), .out_data(p_od));
  dly_line #(.IN_W(64), .OUT_W(32), .DELAY(DLY)) u_dly_line_sp (
    .clk(clk), .rst(rst), .in_valid(s_iv), .in_data(s_id),
    .out_valid(s_ov), .out_data(s_od));

  int n_cmp = 0, n_bad = 0, cyc = 0, gcnt = 0, p_fcyc = 0;
  bit done = 0, p_ph = 0;
  bit [31:0] p_first;
  string pre_tag = "R3";
  bit [32:0] exp_b [NCYC];
  bit [64:0] exp_p [NCYC];
  bit [32:0] exp_s [NCYC];
  string tg_b [NCYC];
  string tg_p [NCYC];
  string tg_s [NCYC];

  task automatic cmp(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_now();
    string t;
    t = (tg_b[cyc] != "") ? tg_b[cyc] : ((cyc < DLY) ? pre_tag : "R2");
    cmp(t, {32'h0, b_ov, b_ov ? b_od : 32'h0}, {32'h0, exp_b[cyc]});
    t = (tg_p[cyc] != "") ? tg_p[cyc] : ((cyc < DLY) ? pre_tag : "R6");
    cmp(t, {p_ov, p_ov ? p_od : 64'h0}, exp_p[cyc]);
    t = (tg_s[cyc] != "") ? tg_s[cyc] : ((cyc < DLY) ? pre_tag : "R8");
    cmp(t, {32'h0, s_ov, s_ov ? s_od : 32'h0}, {32'h0, exp_s[cyc]});
  endtask

  task automatic drive_now(input logic [3:0] mask);
    bit v, sv;
    v  = mask[cyc % 4];
    sv = v && (cyc % 2 == 0);
    b_iv = v;  b_id = 32'hB000_0000 ^ gcnt;
    p_iv = v;  p_id = 32'hC000_0000 ^ gcnt;
    s_iv = sv; s_id = {32'h5000_0000 ^ gcnt, 32'hA000_0000 ^ gcnt};
    if (v) begin
      exp_b[cyc + DLY] = {1'b1, b_id};
      tg_b[cyc + DLY]  = (cyc >= DLY) ? "R10" : "R1";  // R10: past wrap
      if (!p_ph) begin
        p_first = p_id; p_fcyc = cyc; p_ph = 1;
      end else begin
        exp_p[cyc + DLY] = {1'b1, p_id, p_first};
        tg_p[cyc + DLY]  = (cyc == p_fcyc + 1) ? "R5" : "R7";  // R7: gap in pair
        p_ph = 0;
      end
    end
    if (sv) begin
      exp_s[cyc + DLY]     = {1'b1, s_id[31:0]};
      exp_s[cyc + DLY + 1] = {1'b1, s_id[63:32]};
      tg_s[cyc + DLY]      = (mask == 4'hF) ? "R9" : "R8";
      tg_s[cyc + DLY + 1]  = (mask == 4'hF) ? "R9" : "R8";
    end
    gcnt++;
  endtask

  task automatic run_seg(input int len, input logic [3:0] mask);
    for (int i = 0; i < len; i++) begin
      check_now();
      drive_now(mask);
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NCYC; i++) begin
      exp_b[i] = '0; exp_p[i] = '0; exp_s[i] = '0;
      tg_b[i] = ""; tg_p[i] = ""; tg_s[i] = "";
    end
    p_ph = 0;
    cyc  = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    clear_model();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;                 // cycle 0 starts here
    for (int s = 0; s < NSEG; s++) run_seg(int'(SEG[s][15:4]), SEG[s][3:0]);

    // R4: reset in the middle of a full-rate stream
    run_seg(300, 4'b1111);
    rst = 1'b1; b_iv = 0; p_iv = 0; s_iv = 0;
    @(posedge clk); #1;
    cmp("R4", {64'h0, b_ov}, 65'h0);
    cmp("R4", {64'h0, p_ov}, 65'h0);
    cmp("R4", {64'h0, s_ov}, 65'h0);
    rst = 1'b0;
    clear_model();
    pre_tag = "R4";
    run_seg(1000, 4'b1111);
    run_seg(520, 4'b0000);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule